// File: doc/BRIEF.md
# APB Watchdog Timer with Staged Response

This block guards a system against software lockup. A down-counter, programmed and read over an APB slave port, runs whenever the watchdog is enabled. It is loaded from one of sixteen power-of-two timeout lengths. Software proves it is alive by writing a fixed key to the restart register. Each valid key reloads the counter. Until the first valid key arrives, a separate initial timeout length applies, so that boot code can be given a longer window. After that, the normal length applies.

When the counter reaches zero, the block responds in one of two ways. In the direct mode it asserts a system reset pulse at once. In the staged mode it first raises an interrupt and reloads. If no valid key arrives before the next expiry, it then asserts the reset pulse. This happens even if the interrupt was cleared in between. The reset pulse width is programmable from 2 to 256 clock cycles. A pause input freezes the count, for example while a debugger halts the processor. A build parameter can make the watchdog run from reset and ignore any attempt to switch it off. A second parameter sets the base exponent of the timeout lengths. Its default is 16, which gives 64K to 2G cycles.

Top module: `wdog_apb`

## Requirements
- R1: After reset the control, timeout-range and status registers read 0. The interrupt and system reset outputs are low. The count register reads 2^TOP_BASE-1.
- R2: The register word offsets are: control 0x00, timeout range 0x04, count 0x08, restart 0x0C, status 0x10 and clear 0x14. Control bit 0 is enable, bit 1 is mode (1 selects staged) and bits 4:2 are the pulse code. In the range register, bits 3:0 hold the normal code and bits 7:4 hold the initial code. Written fields read back.
- R3: Before the first valid key, the timeout uses the initial code c. The system reset rises 2^(TOP_BASE+c) cycles after the write that enables the watchdog, when mode is 0.
- R4: Writing 0x76 in the low byte of the restart register reloads the counter with the normal length. From then on, the system reset rises 2^(TOP_BASE+n) cycles after that write, and every later period uses the normal code n.
- R5: A restart write with any other low byte leaves the counter running undisturbed.
- R6: In mode 1, the first expiry sets the interrupt output and status bit 0 and reloads the counter. The following expiry asserts the system reset, even if the interrupt was cleared in between.
- R7: A read of the clear register drops the interrupt without reloading the counter. A valid key also drops the interrupt and returns the staged response to its first stage.
- R8: The system reset pulse lasts 2^(code+1) cycles for pulse code 0..7.
- R9: While the pause input is high, the count holds its value. Counting resumes when pause falls.
- R10: Once set, the enable bit stays set until reset. With ALWAYS_EN the watchdog reads as enabled from reset and counts without any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high, so transfers have no wait states |
| pause | input | 1 | Freezes the counter while high |
| wdt_irq | output | 1 | First-stage timeout interrupt |
| wdt_sys_rst | output | 1 | Active-high system reset pulse |

## Verification
Register writes take effect on the clock edge of the APB access phase. Read data is combinational during that phase, so the bench samples it on the falling edge just before the edge. The interrupt and the reset pulse rise on the edge that ends exactly 2^(TOP_BASE+code) cycles after the enabling write or the valid key. The bench keeps a free-running edge counter and records its value when the write completes. It then compares the difference at the first falling edge where the output is seen high, so the time spent in intermediate register reads does not shift the expected value. For the always-enabled variant, the internal two-flop reset release adds two cycles, which gives 18 cycles at code 0. The pulse width is counted in falling-edge samples while the output stays high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // low byte that software must write to the restart register
  localparam logic [7:0] KICK_KEY = 8'h76;

  // register word index, taken from byte address bits 4:2
  typedef enum logic [2:0] {
    OFS_CTRL  = 3'd0,
    OFS_RANGE = 3'd1,
    OFS_COUNT = 3'd2,
    OFS_KICK  = 3'd3,
    OFS_STAT  = 3'd4,
    OFS_CLR   = 3'd5
  } ofs_e;

  // control register image, bit 0 upward: enable, mode, pulse code
  typedef struct packed {
    logic [2:0] pls_code;
    logic       mode;
    logic       en;
  } ctrl_t;

  // timeout range image: initial code in the high nibble
  typedef struct packed {
    logic [3:0] init_code;
    logic [3:0] run_code;
  } range_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CNT_W     = 32,
  parameter bit          ALWAYS_EN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_i,
  output ctrl_t             ctrl_o,
  output range_t            range_o,
  output logic              kick_o,
  output logic              clr_o
);

  logic   access, wr_acc, rd_acc, hit;
  ofs_e   idx;
  logic   wr_ctrl, wr_range;
  logic   en_nxt;
  ctrl_t  ctrl_q, ctrl_d;
  range_t range_q, range_d;
  logic [31:0] rd_data;
  logic   unused_bits;

  assign access = psel_i & penable_i;
  assign wr_acc = access & pwrite_i;
  assign rd_acc = access & ~pwrite_i;
  assign hit    = (paddr_i[ADDR_W-1:5] == '0) && (paddr_i[1:0] == 2'b00);
  assign idx    = ofs_e'(paddr_i[4:2]);

  assign wr_ctrl  = wr_acc & hit & (idx == OFS_CTRL);
  assign wr_range = wr_acc & hit & (idx == OFS_RANGE);
  assign kick_o   = wr_acc & hit & (idx == OFS_KICK) & (pwdata_i[7:0] == KICK_KEY);
  assign clr_o    = rd_acc & hit & (idx == OFS_CLR);

  assign unused_bits = ^pwdata_i[31:8];

  // enable: fixed on, or set-only from software
  if (ALWAYS_EN) begin : g_en_fixed
    assign en_nxt = 1'b1;
  end else begin : g_en_sticky
    assign en_nxt = ctrl_q.en | (wr_ctrl & pwdata_i[0]);
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    range_d = range_q;
    ctrl_d.en = en_nxt;
    if (wr_ctrl) begin
      ctrl_d.mode     = pwdata_i[1];
      ctrl_d.pls_code = pwdata_i[4:2];
    end
    if (wr_range) begin
      range_d = range_t'(pwdata_i[7:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '{pls_code: 3'd0, mode: 1'b0, en: ALWAYS_EN};
      range_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      range_q <= range_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit) begin
      case (idx)
        OFS_CTRL:  rd_data[4:0]       = ctrl_q;
        OFS_RANGE: rd_data[7:0]       = range_q;
        OFS_COUNT: rd_data[CNT_W-1:0] = cnt_i;
        OFS_STAT:  rd_data[0]         = irq_i;
        default:   rd_data            = '0;
      endcase
    end
  end

  assign prdata_o = rd_data;
  assign ctrl_o   = ctrl_q;
  assign range_o  = range_q;

  // R10
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.en |=> ctrl_q.en);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned TOP_BASE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pause_i,
  input  logic             kick_i,
  input  logic [3:0]       run_code_i,
  input  logic [3:0]       init_code_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tmo_o
);

  localparam int unsigned SH_W = $clog2(TOP_BASE + 16);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_CNT = (ONE << TOP_BASE) - ONE;

  logic             kicked_q, kicked_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       sel_code;
  logic [SH_W-1:0]  sh_sel, sh_run;
  logic [CNT_W-1:0] reload_sel, reload_run;
  logic             active;

  // the initial code applies until the first valid key
  assign sel_code   = kicked_q ? run_code_i : init_code_i;
  assign sh_sel     = SH_W'(TOP_BASE) + SH_W'(sel_code);
  assign sh_run     = SH_W'(TOP_BASE) + SH_W'(run_code_i);
  assign reload_sel = (ONE << sh_sel) - ONE;
  assign reload_run = (ONE << sh_run) - ONE;

  assign active = en_i & ~pause_i;
  assign tmo_o  = active & ~kick_i & (cnt_q == '0);

  always_comb begin
    kicked_d = kicked_q | kick_i;
    cnt_d    = cnt_q;
    if (kick_i) begin
      cnt_d = reload_run;
    end else if (!en_i) begin
      cnt_d = reload_sel;
    end else if (tmo_o) begin
      cnt_d = reload_sel;
    end else if (active) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kicked_q <= 1'b0;
      cnt_q    <= RST_CNT;
    end else begin
      kicked_q <= kicked_d;
      cnt_q    <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R9
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pause_i && !kick_i) |=> $stable(cnt_q));

  // R4
  kick_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q != '0));

endmodule

// File: rtl/wdog_resp.sv
module wdog_resp (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tmo_i,
  input  logic       mode_i,
  input  logic [2:0] pls_code_i,
  input  logic       kick_i,
  input  logic       clr_i,
  output logic       irq_o,
  output logic       sys_rst_o
);

  localparam int unsigned PLS_W = 8;

  logic             stage_q, stage_d;
  logic             irq_q, irq_d;
  logic             rst_q, rst_d;
  logic [PLS_W-1:0] left_q, left_d;
  logic [PLS_W:0]   pls_len;
  logic             fire;

  assign pls_len = (PLS_W+1)'(2) << pls_code_i;

  always_comb begin
    stage_d = stage_q;
    irq_d   = irq_q;
    rst_d   = rst_q;
    left_d  = left_q;
    fire    = 1'b0;
    // an expiry during a running pulse is absorbed by it
    if (tmo_i && !rst_q) begin
      if (mode_i && !stage_q) begin
        irq_d   = 1'b1;
        stage_d = 1'b1;
      end else begin
        fire = 1'b1;
      end
    end
    if (fire) begin
      rst_d   = 1'b1;
      left_d  = PLS_W'(pls_len - 1'b1);
      stage_d = 1'b0;
    end else if (rst_q) begin
      if (left_q == '0) begin
        rst_d = 1'b0;
      end else begin
        left_d = left_q - 1'b1;
      end
    end
    if (clr_i) begin
      irq_d = 1'b0;
    end
    if (kick_i) begin
      irq_d   = 1'b0;
      stage_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      left_q  <= '0;
    end else begin
      stage_q <= stage_d;
      irq_q   <= irq_d;
      rst_q   <= rst_d;
      left_q  <= left_d;
    end
  end

  assign irq_o     = irq_q;
  assign sys_rst_o = rst_q;

  // R8
  pls_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(tmo_i));

  // R7
  kick_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !irq_o);

  // R6
  staged_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_o) && $past(mode_i)) |-> $past(stage_q));

endmodule

// File: rtl/wdog_apb.sv
module wdog_apb
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned TOP_BASE  = 16,
  parameter bit          ALWAYS_EN = 1'b0
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              pause,
  output logic              wdt_irq,
  output logic              wdt_sys_rst
);

  localparam int unsigned CNT_W = TOP_BASE + 16;

  logic [1:0]       rsync_q;
  logic             rst_n;
  ctrl_t            ctrl;
  range_t           range;
  logic             kick, clr, tmo;
  logic [CNT_W-1:0] cnt;

  // asynchronous assertion, two-flop synchronous release
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_n  = rsync_q[1];
  assign pready = 1'b1;

  wdog_regs #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .ALWAYS_EN(ALWAYS_EN)
  ) u_regs (
    .clk_i    (pclk),
    .rst_ni   (rst_n),
    .psel_i   (psel),
    .penable_i(penable),
    .pwrite_i (pwrite),
    .paddr_i  (paddr),
    .pwdata_i (pwdata),
    .prdata_o (prdata),
    .cnt_i    (cnt),
    .irq_i    (wdt_irq),
    .ctrl_o   (ctrl),
    .range_o  (range),
    .kick_o   (kick),
    .clr_o    (clr)
  );

  wdog_counter #(
    .CNT_W   (CNT_W),
    .TOP_BASE(TOP_BASE)
  ) u_counter (
    .clk_i      (pclk),
    .rst_ni     (rst_n),
    .en_i       (ctrl.en),
    .pause_i    (pause),
    .kick_i     (kick),
    .run_code_i (range.run_code),
    .init_code_i(range.init_code),
    .cnt_o      (cnt),
    .tmo_o      (tmo)
  );

  wdog_resp u_resp (
    .clk_i     (pclk),
    .rst_ni    (rst_n),
    .tmo_i     (tmo),
    .mode_i    (ctrl.mode),
    .pls_code_i(ctrl.pls_code),
    .kick_i    (kick),
    .clr_i     (clr),
    .irq_o     (wdt_irq),
    .sys_rst_o (wdt_sys_rst)
  );

endmodule

// File: tb/test_wdog_apb.sv
`timescale 1ns/1ps
module test_wdog_apb;

  localparam int unsigned TB_BASE = 4;
  // columns: mode, pulse code, initial code, irq delay (0 = none), reset delay, pulse length
  localparam int VEC [5][6] = '{
    '{0, 0, 0,   0,  16,   2},
    '{0, 3, 2,   0,  64,  16},
    '{0, 7, 1,   0,  32, 256},
    '{1, 1, 0,  16,  32,   4},
    '{1, 5, 3, 128, 256,  64}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite, pause;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata, prdata_ae;
  logic        pready, pready_ae;
  logic        irq, sys_rst, irq_ae, sys_rst_ae;

  int unsigned cyc = 0;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_apb #(.ADDR_W(8), .TOP_BASE(TB_BASE), .ALWAYS_EN(1'b0)) i_wdog_apb (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pause(pause),
    .wdt_irq(irq), .wdt_sys_rst(sys_rst));

  wdog_apb #(.ADDR_W(8), .TOP_BASE(TB_BASE), .ALWAYS_EN(1'b1)) i_wdog_apb_ae (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_ae), .pready(pready_ae), .pause(pause),
    .wdt_irq(irq_ae), .wdt_sys_rst(sys_rst_ae));

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d_ae);
    @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #1; d = prdata; d_ae = prdata_ae;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic do_reset(output int unsigned t_rel);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_rel = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d_ae, v1, v2;
    int unsigned t0, t1, trel, len;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0; pause = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);

    // R10 always-enabled variant counts from reset with no write (2 sync cycles + 16)
    do_reset(trel);
    while (!sys_rst_ae) @(negedge clk);
    chk("R10 always-on first timeout", cyc - trel, 18);

    // R1 reset state
    do_reset(trel);
    repeat (3) @(negedge clk);
    chk("R1 irq low", irq, 0);
    chk("R1 sys_rst low", sys_rst, 0);
    apb_rd(8'h00, d, d_ae);
    chk("R1 ctrl", d, 0);
    chk("R10 always-on enable bit", d_ae[0], 1);
    apb_rd(8'h04, d, d_ae);
    chk("R1 range", d, 0);
    apb_rd(8'h10, d, d_ae);
    chk("R1 status", d, 0);
    apb_rd(8'h08, d, d_ae);
    chk("R1 count", d, 15);

    // R3 R6 R8 vector table
    for (int i = 0; i < 5; i++) begin
      do_reset(trel);
      repeat (3) @(negedge clk);
      apb_wr(8'h04, 32'(VEC[i][2]) << 4);
      apb_wr(8'h00, (32'(VEC[i][1]) << 2) | (32'(VEC[i][0]) << 1) | 32'd1);
      t0 = cyc;
      if (VEC[i][3] != 0) begin
        while (!irq && !sys_rst) @(negedge clk);
        chk("R6 first expiry raises irq", cyc - t0, VEC[i][3]);
        chk("R6 no reset at first expiry", sys_rst, 0);
      end
      while (!sys_rst) @(negedge clk);
      chk("R3 timeout to reset", cyc - t0, VEC[i][4]);
      if (VEC[i][0] == 0) chk("R3 direct mode leaves irq low", irq, 0);
      len = 0;
      while (sys_rst) begin len++; @(negedge clk); end
      chk("R8 pulse length", len, VEC[i][5]);
    end

    // R5 R4 restart key
    do_reset(trel);
    repeat (3) @(negedge clk);
    apb_wr(8'h04, 32'h03);
    apb_wr(8'h00, 32'h01);
    apb_wr(8'h0C, 32'h12);
    apb_rd(8'h08, d, d_ae);
    chk("R5 wrong key ignored", (d < 16) ? 1 : 0, 1);
    apb_wr(8'h0C, 32'h76);
    t0 = cyc;
    apb_rd(8'h08, d, d_ae);
    chk("R4 key reloads normal period", (d > 100) ? 1 : 0, 1);
    while (!sys_rst) @(negedge clk);
    chk("R4 timeout after key", cyc - t0, 128);
    while (sys_rst) @(negedge clk);
    while (!sys_rst) @(negedge clk);
    chk("R4 later period uses normal code", cyc - t0, 256);

    // R6 R7 clear by read does not restart
    do_reset(trel);
    repeat (3) @(negedge clk);
    apb_wr(8'h00, 32'h03);
    t0 = cyc;
    while (!irq && !sys_rst) @(negedge clk);
    chk("R6 irq time", cyc - t0, 16);
    apb_rd(8'h10, d, d_ae);
    chk("R6 status bit", d, 1);
    apb_rd(8'h14, d, d_ae);
    chk("R7 clear drops irq", irq, 0);
    apb_rd(8'h10, d, d_ae);
    chk("R7 status after clear", d, 0);
    while (!sys_rst) @(negedge clk);
    chk("R6 reset despite clear", cyc - t0, 32);

    // R7 key clears irq and stage
    do_reset(trel);
    repeat (3) @(negedge clk);
    apb_wr(8'h00, 32'h03);
    while (!irq && !sys_rst) @(negedge clk);
    apb_wr(8'h0C, 32'h76);
    t1 = cyc;
    chk("R7 key drops irq", irq, 0);
    while (!irq && !sys_rst) @(negedge clk);
    chk("R7 stage restarts: irq again", irq, 1);
    chk("R7 stage restarts: no reset", sys_rst, 0);
    chk("R7 stage restart time", cyc - t1, 16);

    // R9 pause
    do_reset(trel);
    repeat (3) @(negedge clk);
    apb_wr(8'h04, 32'h20);
    apb_wr(8'h00, 32'h01);
    @(negedge clk); pause = 1'b1;
    apb_rd(8'h08, v1, d_ae);
    repeat (20) @(negedge clk);
    apb_rd(8'h08, v2, d_ae);
    chk("R9 count frozen", v2, v1);
    pause = 1'b0;
    repeat (3) @(negedge clk);
    apb_rd(8'h08, d, d_ae);
    chk("R9 count resumes", (d < v2) ? 1 : 0, 1);

    // R2 R10 readback and sticky enable
    do_reset(trel);
    repeat (3) @(negedge clk);
    apb_wr(8'h04, 32'h5A);
    apb_rd(8'h04, d, d_ae);
    chk("R2 range readback", d, 32'h5A);
    apb_wr(8'h00, 32'h0D);
    apb_rd(8'h00, d, d_ae);
    chk("R2 ctrl readback", d, 32'h0D);
    apb_wr(8'h00, 32'h1E);
    apb_rd(8'h00, d, d_ae);
    chk("R10 enable stays set", d, 32'h1F);
    chk("R10 always-on ignores clear", d_ae[0], 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule